// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block resolves the indexed addressing form of an 8-bit processor with four 16-bit pointer registers, two 8-bit accumulators and a program counter. The core pulses `start_i` with the postbyte and a snapshot of its registers. `pc_i` must point at the first byte after the postbyte. The block fetches any trailing offset or address bytes through a byte-read handshake and computes the address. For an indirect form it then reads a 16-bit pointer. It finishes with a one-cycle `done_o` that carries the effective address, an illegal flag, and an optional register write-back for the auto-modify forms.

The postbyte fields work as follows. Bit 7 clear selects a short form: bits 4..0 are a signed offset added to the pointer chosen by bits 6..5, and the form is never indirect. Bit 7 set makes bits 3..0 a sub-mode code and bit 4 the indirect flag. Every 16-bit quantity in memory is read high byte first.

Top module: `idx_ea_gen`

## Requirements
- R1: With postbyte bit 7 = 0, the address is the selected pointer plus the sign-extended 5-bit field in bits 4..0. No byte is read, there is no write-back, and `done_o` rises on the second clock edge after the edge that accepts `start_i`.
- R2: Bits 6..5 choose the pointer: 00 = X, 01 = Y, 10 = U, 11 = S. Sub-mode 0100 uses that pointer with no offset, and `wb_sel_o` reports the same code.
- R3: Sub-mode 1000 adds a sign-extended byte read at `pc_i`. Sub-mode 1001 adds a 16-bit word read at `pc_i` (high byte) and `pc_i`+1 (low byte).
- R4: Sub-mode 0110 adds A sign-extended, 0101 adds B sign-extended, and 1011 adds the 16-bit value with A high and B low.
- R5: Sub-modes 0000 and 0001 address the pointer's old value and write back old+1 and old+2. `wb_en_o` is high only in the `done_o` cycle.
- R6: Sub-modes 0010 and 0011 subtract 1 and 2 first. The address and the write-back value are both the decremented value.
- R7: Sub-modes 1100 and 1101 add a signed byte or word offset, fetched as in R3, to `pc_i` plus the number of offset bytes. Bits 6..5 have no effect on the address.
- R8: With bit 7 = 1 and bit 4 = 1, the computed address is used to read a word, and that word becomes `ea_o`. Auto-modify write-back still applies.
- R9: Postbyte 1001_1111 reads a 16-bit address at `pc_i`, then reads the pointer word at that address, which becomes `ea_o`. There is no write-back.
- R10: Sub-modes 0111, 1010 and 1110 are illegal, as are 1111 with bit 4 = 0 and 0000/0010 with bit 4 = 1. An illegal postbyte gives `done_o` with `illegal_o` = 1, `wb_en_o` = 0 and no memory read.
- R11: `rd_req_o` and `rd_addr_o` hold until `rd_ack_i`, where a byte moves on the edge with both high. `done_o` is a single-cycle pulse, and `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a resolution; accepted when idle |
| postbyte_i | input | 8 | Indexed postbyte |
| reg_x_i | input | 16 | Pointer X |
| reg_y_i | input | 16 | Pointer Y |
| reg_u_i | input | 16 | Pointer U |
| reg_s_i | input | 16 | Pointer S |
| acc_a_i | input | 8 | Accumulator A |
| acc_b_i | input | 8 | Accumulator B |
| pc_i | input | 16 | Address of the byte after the postbyte |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | 16 | Byte read address |
| rd_ack_i | input | 1 | Read data valid; completes the request |
| rd_data_i | input | 8 | Read data |
| busy_o | output | 1 | Resolution in progress |
| done_o | output | 1 | One-cycle completion strobe |
| ea_o | output | 16 | Effective address, valid with done_o |
| illegal_o | output | 1 | Illegal postbyte, valid with done_o |
| wb_en_o | output | 1 | Pointer write-back enable |
| wb_sel_o | output | 2 | Pointer to write back, same code as bits 6..5 |
| wb_val_o | output | 16 | Write-back value |

## Verification
Assertions check several properties on every cycle. A request stays up with a steady address until it is acknowledged. `done_o` never lasts two cycles. An illegal result never carries a write-back, and a write-back never appears outside `done_o`. A short-form start completes in exactly two edges. A direct decrement reports the same address and write-back value.

The address arithmetic needs the directed scenarios with a known memory pattern. These cover the sign extension of every offset source, the PC base after its offset bytes, the high-first byte order, the two-level indirect reads, the rejection of the illegal codes, and a start ignored mid-operation under a slow memory.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [1:0] {BASE_REG, BASE_PC, BASE_ABS} base_e;
  typedef enum logic [2:0] {OFS_NONE, OFS_INL5, OFS_BYTE, OFS_WORD,
                            OFS_ACCA, OFS_ACCB, OFS_ACCD} ofs_e;
  typedef enum logic [2:0] {MOD_NONE, MOD_INC1, MOD_INC2, MOD_DEC1, MOD_DEC2} mod_e;
  typedef enum logic [2:0] {S_IDLE, S_PRE, S_FETCH, S_CALC, S_PTR, S_FIN} st_e;

  typedef struct packed {
    logic       illegal;
    logic       indirect;
    logic [1:0] n_fetch;
    logic [1:0] rsel;
    base_e      base;
    ofs_e       ofs;
    mod_e       modify;
  } dec_t;
endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_pkg::*;
(
  input  logic [7:0] pb_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o          = '0;
    dec_o.rsel     = pb_i[6:5];
    dec_o.base     = BASE_REG;
    dec_o.ofs      = OFS_NONE;
    dec_o.modify   = MOD_NONE;
    if (!pb_i[7]) begin
      dec_o.ofs = OFS_INL5;
    end else begin
      dec_o.indirect = pb_i[4];
      case (pb_i[3:0])
        4'b0000: begin dec_o.modify = MOD_INC1; dec_o.illegal = pb_i[4]; end
        4'b0001: dec_o.modify = MOD_INC2;
        4'b0010: begin dec_o.modify = MOD_DEC1; dec_o.illegal = pb_i[4]; end
        4'b0011: dec_o.modify = MOD_DEC2;
        4'b0100: dec_o.ofs = OFS_NONE;
        4'b0101: dec_o.ofs = OFS_ACCB;
        4'b0110: dec_o.ofs = OFS_ACCA;
        4'b1011: dec_o.ofs = OFS_ACCD;
        4'b1000: begin dec_o.ofs = OFS_BYTE; dec_o.n_fetch = 2'd1; end
        4'b1001: begin dec_o.ofs = OFS_WORD; dec_o.n_fetch = 2'd2; end
        4'b1100: begin dec_o.base = BASE_PC; dec_o.ofs = OFS_BYTE; dec_o.n_fetch = 2'd1; end
        4'b1101: begin dec_o.base = BASE_PC; dec_o.ofs = OFS_WORD; dec_o.n_fetch = 2'd2; end
        4'b1111: begin
          dec_o.base    = BASE_ABS;
          dec_o.ofs     = OFS_WORD;
          dec_o.n_fetch = 2'd2;
          dec_o.illegal = !pb_i[4];
        end
        default: dec_o.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/idx_agen.sv
module idx_agen
  import idx_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [3:0][AW-1:0] ptr_i,
  input  logic [DW-1:0]      acc_a_i,
  input  logic [DW-1:0]      acc_b_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [4:0]         inl_i,
  input  logic [AW-1:0]      fetched_i,
  input  logic [1:0]         rsel_i,
  input  logic [1:0]         n_fetch_i,
  input  base_e              base_i,
  input  ofs_e               ofs_i,
  input  mod_e               modify_i,
  output logic [AW-1:0]      addr_o,
  output logic [AW-1:0]      wb_val_o
);
  logic [AW-1:0] base_v, base_m, ofs_v;

  always_comb begin
    case (base_i)
      BASE_REG: base_v = ptr_i[rsel_i];
      BASE_PC:  base_v = pc_i + {{(AW-2){1'b0}}, n_fetch_i};
      default:  base_v = '0;
    endcase

    case (ofs_i)
      OFS_INL5: ofs_v = {{(AW-5){inl_i[4]}}, inl_i};
      OFS_BYTE: ofs_v = {{DW{fetched_i[DW-1]}}, fetched_i[DW-1:0]};
      OFS_WORD: ofs_v = fetched_i;
      OFS_ACCA: ofs_v = {{DW{acc_a_i[DW-1]}}, acc_a_i};
      OFS_ACCB: ofs_v = {{DW{acc_b_i[DW-1]}}, acc_b_i};
      OFS_ACCD: ofs_v = {acc_a_i, acc_b_i};
      default:  ofs_v = '0;
    endcase

    // pre-decrement forms address the decremented value
    case (modify_i)
      MOD_DEC1: base_m = base_v - AW'(1);
      MOD_DEC2: base_m = base_v - AW'(2);
      default:  base_m = base_v;
    endcase

    addr_o = base_m + ofs_v;

    case (modify_i)
      MOD_INC1: wb_val_o = base_v + AW'(1);
      MOD_INC2: wb_val_o = base_v + AW'(2);
      default:  wb_val_o = base_m;
    endcase
  end
endmodule

// File: rtl/idx_seq.sv
module idx_seq
  import idx_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ill_i,
  input  logic          ind_i,
  input  logic          mod_i,
  input  logic [1:0]    n_fetch_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] wbv_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [AW-1:0] fetched_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic          illegal_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o
);
  st_e           st;
  logic [1:0]    cnt;
  logic [AW-1:0] sh, ea_q, wbv_q;
  logic          wben_q, ill_q;

  assign accept_o  = start_i && (st == S_IDLE);
  assign busy_o    = (st != S_IDLE);
  assign rd_req_o  = (st == S_FETCH) || (st == S_PTR);
  assign rd_addr_o = ((st == S_PTR) ? ea_q : pc_i) + {{(AW-2){1'b0}}, cnt};
  assign fetched_o = sh;
  assign done_o    = (st == S_FIN);
  assign ea_o      = ea_q;
  assign illegal_o = ill_q;
  assign wb_en_o   = wben_q && (st == S_FIN);
  assign wb_val_o  = wbv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ea_q   <= '0;
      wbv_q  <= '0;
      wben_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st     <= S_PRE;
          cnt    <= '0;
          wben_q <= 1'b0;
          ill_q  <= 1'b0;
        end
        S_PRE: begin
          if (ill_i) begin
            ill_q <= 1'b1;
            st    <= S_FIN;
          end else if (n_fetch_i != 2'd0) begin
            st <= S_FETCH;
          end else begin
            ea_q   <= addr_i;
            wbv_q  <= wbv_i;
            wben_q <= mod_i;
            cnt    <= '0;
            st     <= ind_i ? S_PTR : S_FIN;
          end
        end
        S_FETCH: if (rd_ack_i) begin
          sh  <= {sh[DW-1:0], rd_data_i};
          cnt <= cnt + 2'd1;
          if (cnt + 2'd1 == n_fetch_i) st <= S_CALC;
        end
        S_CALC: begin
          ea_q   <= addr_i;
          wbv_q  <= wbv_i;
          wben_q <= mod_i;
          cnt    <= '0;
          st     <= ind_i ? S_PTR : S_FIN;
        end
        S_PTR: if (rd_ack_i) begin
          sh  <= {sh[DW-1:0], rd_data_i};
          cnt <= cnt + 2'd1;
          if (cnt == 2'd1) begin
            ea_q <= {sh[DW-1:0], rd_data_i};
            st   <= S_FIN;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_ill_no_wb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && illegal_o |-> !wb_en_o);
  p_wb_in_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o);
  p_ill_no_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_PRE) && ill_i |=> !rd_req_o && done_o);
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [7:0]            postbyte_i,
  input  logic [2*DATA_W-1:0]   reg_x_i,
  input  logic [2*DATA_W-1:0]   reg_y_i,
  input  logic [2*DATA_W-1:0]   reg_u_i,
  input  logic [2*DATA_W-1:0]   reg_s_i,
  input  logic [DATA_W-1:0]     acc_a_i,
  input  logic [DATA_W-1:0]     acc_b_i,
  input  logic [2*DATA_W-1:0]   pc_i,
  output logic                  rd_req_o,
  output logic [2*DATA_W-1:0]   rd_addr_o,
  input  logic                  rd_ack_i,
  input  logic [DATA_W-1:0]     rd_data_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [2*DATA_W-1:0]   ea_o,
  output logic                  illegal_o,
  output logic                  wb_en_o,
  output logic [1:0]            wb_sel_o,
  output logic [2*DATA_W-1:0]   wb_val_o
);
  localparam int AW = 2 * DATA_W;

  logic [7:0]          pb_q;
  logic [3:0][AW-1:0]  ptr_q;
  logic [DATA_W-1:0]   a_q, b_q;
  logic [AW-1:0]       pc_q, fetched, calc_addr, calc_wbv;
  logic                accept;
  dec_t                dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pb_q  <= '0;
      ptr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      pc_q  <= '0;
    end else if (accept) begin
      pb_q  <= postbyte_i;
      ptr_q <= {reg_s_i, reg_u_i, reg_y_i, reg_x_i};
      a_q   <= acc_a_i;
      b_q   <= acc_b_i;
      pc_q  <= pc_i;
    end
  end

  idx_decode i_decode (
    .pb_i  (pb_q),
    .dec_o (dec)
  );

  idx_agen #(.DW(DATA_W)) i_agen (
    .ptr_i     (ptr_q),
    .acc_a_i   (a_q),
    .acc_b_i   (b_q),
    .pc_i      (pc_q),
    .inl_i     (pb_q[4:0]),
    .fetched_i (fetched),
    .rsel_i    (dec.rsel),
    .n_fetch_i (dec.n_fetch),
    .base_i    (dec.base),
    .ofs_i     (dec.ofs),
    .modify_i  (dec.modify),
    .addr_o    (calc_addr),
    .wb_val_o  (calc_wbv)
  );

  idx_seq #(.DW(DATA_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ill_i     (dec.illegal),
    .ind_i     (dec.indirect),
    .mod_i     (dec.modify != MOD_NONE),
    .n_fetch_i (dec.n_fetch),
    .pc_i      (pc_q),
    .addr_i    (calc_addr),
    .wbv_i     (calc_wbv),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .fetched_o (fetched),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .rd_data_i (rd_data_i),
    .done_o    (done_o),
    .ea_o      (ea_o),
    .illegal_o (illegal_o),
    .wb_en_o   (wb_en_o),
    .wb_val_o  (wb_val_o)
  );

  assign wb_sel_o = pb_q[6:5];

  p_short_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !postbyte_i[7] |=> ##1 done_o && !illegal_o);
  p_dec_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && wb_en_o && pb_q[7] && !pb_q[4] && (pb_q[3:1] == 3'b001)
    |-> ea_o == wb_val_o);
endmodule

// File: tb/test_idx_ea_gen.sv
module test_idx_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  postbyte = '0;
  logic [15:0] rx = 16'h1000, ry = 16'h2000, ru = 16'h3000, rs = 16'h4000;
  logic [7:0]  acc_a = 8'h80, acc_b = 8'h05;
  logic [15:0] pc = 16'h6000;
  logic        rd_req, rd_ack = 1'b0;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        busy, done, illegal, wb_en;
  logic [15:0] ea, wb_val;
  logic [1:0]  wb_sel;

  int errors = 0, checks = 0;
  int ack_delay = 0, wcnt = 0, reads = 0, cycles = 0;
  logic [15:0] first_addr;
  logic [15:0] r_ea, r_wbv;
  logic        r_ill, r_wben;
  logic [1:0]  r_sel;
  int          r_lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ea_gen i_idx_ea_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .postbyte_i(postbyte),
    .reg_x_i(rx), .reg_y_i(ry), .reg_u_i(ru), .reg_s_i(rs),
    .acc_a_i(acc_a), .acc_b_i(acc_b), .pc_i(pc),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .ea_o(ea), .illegal_o(illegal),
    .wb_en_o(wb_en), .wb_sel_o(wb_sel), .wb_val_o(wb_val)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [15:0] mw(input logic [15:0] a);
    return {mb(a), mb(a + 16'd1)};
  endfunction
  function automatic logic [15:0] s8(input logic [7:0] b);
    return {{8{b[7]}}, b};
  endfunction

  // memory model: ack after ack_delay waiting cycles
  always @(negedge clk) begin
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (wcnt >= ack_delay) begin
        rd_ack = 1'b1;
        rd_data = mb(rd_addr);
        reads++;
        if (reads == 1) first_addr = rd_addr;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] pb, input logic inject);
    @(negedge clk);
    postbyte = pb; start = 1'b1; reads = 0;
    @(negedge clk);
    start = 1'b0;
    r_lat = 1;
    while (!done && r_lat < 500) begin
      @(negedge clk);
      r_lat++;
      if (inject && r_lat == 3) begin postbyte = 8'hE4; start = 1'b1; end
      if (inject && r_lat == 4) start = 1'b0;
    end
    r_ea = ea; r_ill = illegal; r_wben = wb_en; r_sel = wb_sel; r_wbv = wb_val;
  endtask

  task automatic t_reset;
    check(!busy && !done && !rd_req && !wb_en, "R11 reset idle", {12'h0, busy, done, rd_req, wb_en}, 16'h0);
  endtask

  task automatic t_short;
    run_op(8'h3F, 0);
    check(r_ea == 16'h1FFF, "R1 Y-1", r_ea, 16'h1FFF);
    check(r_lat == 2 && reads == 0 && !r_wben, "R1 latency/no read", 16'(r_lat), 16'd2);
    run_op(8'h4F, 0);
    check(r_ea == 16'h300F, "R1 U+15", r_ea, 16'h300F);
  endtask

  task automatic t_regsel;
    run_op(8'h84, 0); check(r_ea == rx && r_sel == 2'd0, "R2 X", r_ea, rx);
    run_op(8'hA4, 0); check(r_ea == ry && r_sel == 2'd1, "R2 Y", r_ea, ry);
    run_op(8'hC4, 0); check(r_ea == ru && r_sel == 2'd2, "R2 U", r_ea, ru);
    run_op(8'hE4, 0); check(r_ea == rs && r_sel == 2'd3, "R2 S", r_ea, rs);
  endtask

  task automatic t_fetch_ofs;
    run_op(8'h88, 0);
    check(r_ea == rx + s8(mb(pc)), "R3 byte ofs", r_ea, rx + s8(mb(pc)));
    run_op(8'h89, 0);
    check(r_ea == rx + mw(pc), "R3 word ofs", r_ea, rx + mw(pc));
    check(reads == 2 && first_addr == pc, "R3 fetch addr", first_addr, pc);
  endtask

  task automatic t_acc;
    run_op(8'h86, 0); check(r_ea == 16'h0F80, "R4 A", r_ea, 16'h0F80);
    run_op(8'h85, 0); check(r_ea == 16'h1005, "R4 B", r_ea, 16'h1005);
    run_op(8'h8B, 0); check(r_ea == 16'h9005, "R4 D", r_ea, 16'h9005);
  endtask

  task automatic t_inc;
    run_op(8'h80, 0);
    check(r_ea == 16'h1000 && r_wben && r_sel == 2'd0, "R5 inc1 ea", r_ea, 16'h1000);
    check(r_wbv == 16'h1001, "R5 inc1 wb", r_wbv, 16'h1001);
    run_op(8'hA1, 0);
    check(r_ea == 16'h2000 && r_wbv == 16'h2002 && r_sel == 2'd1, "R5 inc2", r_wbv, 16'h2002);
    @(negedge clk);
    check(!wb_en, "R5 wb only in done", {15'h0, wb_en}, 16'h0);
  endtask

  task automatic t_dec;
    run_op(8'hC2, 0);
    check(r_ea == 16'h2FFF && r_wbv == 16'h2FFF && r_wben, "R6 dec1", r_ea, 16'h2FFF);
    run_op(8'hE3, 0);
    check(r_ea == 16'h3FFE && r_wbv == 16'h3FFE && r_sel == 2'd3, "R6 dec2", r_ea, 16'h3FFE);
  endtask

  task automatic t_pcrel;
    logic [15:0] e8, e16;
    e8 = pc + 16'd1 + s8(mb(pc));
    e16 = pc + 16'd2 + mw(pc);
    run_op(8'h8C, 0); check(r_ea == e8, "R7 pc byte", r_ea, e8);
    run_op(8'hEC, 0); check(r_ea == e8, "R7 pc byte bits65 ignored", r_ea, e8);
    run_op(8'hED, 0); check(r_ea == e16, "R7 pc word", r_ea, e16);
  endtask

  task automatic t_indirect;
    run_op(8'h94, 0);
    check(r_ea == mw(rx) && reads == 2 && first_addr == rx, "R8 [X]", r_ea, mw(rx));
    run_op(8'hB1, 0);
    check(r_ea == mw(ry) && r_wben && r_wbv == 16'h2002, "R8 [Y++]", r_ea, mw(ry));
    run_op(8'h98, 0);
    check(r_ea == mw(rx + s8(mb(pc))) && reads == 3, "R8 [n8,X]", r_ea, mw(rx + s8(mb(pc))));
  endtask

  task automatic t_extind;
    logic [15:0] e;
    e = mw(mw(pc));
    run_op(8'h9F, 0);
    check(r_ea == e && !r_wben && !r_ill && reads == 4, "R9 extended indirect", r_ea, e);
  endtask

  task automatic t_illegal;
    logic [7:0] codes [6] = '{8'h87, 8'h8A, 8'h8E, 8'h8F, 8'h90, 8'h92};
    foreach (codes[i]) begin
      run_op(codes[i], 0);
      check(r_ill && !r_wben && reads == 0, "R10 illegal code", {8'h0, codes[i]}, 16'h0);
    end
    run_op(8'h91, 0);
    check(!r_ill, "R10 legal [,X++]", {15'h0, r_ill}, 16'h0);
  endtask

  task automatic t_busy;
    ack_delay = 3;
    run_op(8'h89, 1);
    check(r_ea == rx + mw(pc), "R11 start ignored while busy", r_ea, rx + mw(pc));
    @(negedge clk);
    check(!done && !busy, "R11 done one cycle", {14'h0, done, busy}, 16'h0);
    ack_delay = 0;
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_short();
    t_regsel();
    t_fetch_ofs();
    t_acc();
    t_inc();
    t_dec();
    t_pcrel();
    t_indirect();
    t_extind();
    t_illegal();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule